// File: doc/BRIEF.md
# I2C Host Byte Buffer with Clock-Stretch Handshake

This block couples an 8-bit microprocessor-style parallel bus (chip select, read and write strobes, one register-select line) to the byte level of an I2C controller. It keeps a shift register for outgoing and incoming bytes, a separate read buffer for the host, and a small control register. A host data write in transmit mode loads the shift register and, when serial operation is enabled, fires a one-cycle start pulse toward the bit engine. In receive mode, each byte reported complete by the bit engine is copied into the read buffer, and SCL is then held low until the host reads it.

Reading works one byte behind the bus. The first data read after the address phase returns stale contents, releases the stretch and starts reception of the first byte. Each later read returns the byte received before it and starts the next one. A pending flag, active low, marks every finished byte. A minimum spacing between host accesses is enforced. An access that breaks the spacing is dropped and raises a sticky violation flag.

Top module: `i2c_byte_buf`

## Requirements
- R1: After reset, SCL hold is 0, the pending flag is 1, the start pulse is 0, the violation flag is 0, and the control bits are 0.
- R2: With the select line at 1, `data_o` returns status as follows: bit 7 is the pending flag, bit 2 is the violation flag, bit 1 is serial enable, bit 0 is transmit mode, and the other bits are 0. With the select line at 0, `data_o` returns the read buffer. A write with the select line at 1 loads serial enable from data bit 1 and transmit mode from data bit 0.
- R3: A data write with transmit mode and serial enable both set loads `tx_byte_o` and raises `start_o` for one cycle, in the cycle after the first clock edge that samples the strobe. `tx_dir_o` is 1 during that pulse.
- R4: A data write with serial enable at 0 still loads `tx_byte_o` but produces no start pulse. Later control writes do not start it either.
- R5: When `done_i` is sampled in receive mode, `rx_byte_i` goes into the read buffer and the shift register, and `scl_hold_o` is 1 from the next cycle.
- R6: SCL hold stays 1 while the data read strobe is active and drops one cycle after the strobe ends. In the same cycle, a start pulse with `tx_dir_o` at 0 is issued, but only if serial enable is 1 and the block is in receive mode.
- R7: The first data read after the address byte returns the stale buffer. Each later read returns the byte whose reception the previous read started.
- R8: An access that begins fewer than the minimum spacing of clock cycles after the last accepted access has no effect, and it sets `viol_o`. `viol_o` stays set until reset.
- R9: `pend_n_o` goes to 0 one cycle after `done_i`. It returns to 1 on an accepted data-register access. Control-register accesses leave it unchanged.
- R10: The minimum spacing is 6 cycles by default and 3 cycles when `SLOW_CLK` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| a0_i | input | 1 | Register select: 0 data, 1 control/status |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| start_o | output | 1 | One-cycle byte start toward the bit engine |
| tx_dir_o | output | 1 | 1 transmit, 0 receive |
| tx_byte_o | output | 8 | Shift register contents |
| done_i | input | 1 | Byte and acknowledge finished (one-cycle pulse) |
| rx_byte_i | input | 8 | Byte received by the bit engine |
| scl_hold_o | output | 1 | Hold SCL low |
| pend_n_o | output | 1 | Byte pending, active low |
| viol_o | output | 1 | Sticky access-spacing violation |

## Verification
The bench builds two instances on the same bus: one with `SLOW_CLK` at 0, which carries the whole functional run, and one with `SLOW_CLK` at 1. Accesses placed 3 cycles apart are dropped by the first instance and accepted by the second. Accesses placed 2 cycles apart are dropped by both. This puts both spacing limits within reach in a single run. A bit-engine model in the bench answers every start pulse with a done pulse, so the dummy-read offset, the stretch release and the case with serial operation disabled can all be reached.

// File: rtl/i2c_bb_pkg.sv
package i2c_bb_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic ser_en;
    logic tx_mode;
  } ctrl_t;

  localparam int unsigned ST_PEND_BIT = 7;
  localparam int unsigned ST_VIOL_BIT = 2;
endpackage

// File: rtl/i2c_bb_host_port.sv
module i2c_bb_host_port #(
  parameter bit          SLOW_CLK = 1'b0,
  parameter int unsigned DW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          a0_i,
  input  logic [DW-1:0] data_i,
  output logic          st_o,
  output logic          st_wr_o,
  output logic          st_a0_o,
  output logic [DW-1:0] st_data_o,
  output logic          end_dread_o,
  output logic          viol_o
);
  localparam int unsigned GAP_CYC = SLOW_CLK ? 3 : 6;
  localparam int unsigned CW      = $clog2(GAP_CYC + 1);

  logic          strb, strb_q, rise, fall;
  logic          active_q, wr_q, a0_q, viol_q;
  logic [CW-1:0] gap_q;

  assign strb = !cs_ni && !(rd_ni && wr_ni);
  assign rise = strb && !strb_q;
  assign fall = !strb && strb_q;

  assign st_o        = rise && (gap_q >= CW'(GAP_CYC));
  assign st_wr_o     = !wr_ni;
  assign st_a0_o     = a0_i;
  assign st_data_o   = data_i;
  assign end_dread_o = fall && active_q && !a0_q && !wr_q;
  assign viol_o      = viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q   <= 1'b0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      a0_q     <= 1'b0;
      viol_q   <= 1'b0;
      gap_q    <= CW'(GAP_CYC);
    end else begin
      strb_q <= strb;
      if (st_o) begin
        gap_q    <= CW'(1);
        active_q <= 1'b1;
        wr_q     <= !wr_ni;
        a0_q     <= a0_i;
      end else begin
        if (gap_q < CW'(GAP_CYC)) gap_q <= gap_q + CW'(1);
        if (fall) active_q <= 1'b0;
      end
      if (rise && !st_o) viol_q <= 1'b1;
    end
  end

  p_viol_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
  p_early_access_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && !st_o) |=> viol_o);
endmodule

// File: rtl/i2c_bb_byte_core.sv
module i2c_bb_byte_core
  import i2c_bb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_i,
  input  logic          st_wr_i,
  input  logic          st_a0_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          end_dread_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_byte_i,
  output logic          start_o,
  output logic          tx_dir_o,
  output logic [DW-1:0] tx_byte_o,
  output logic [DW-1:0] rbuf_o,
  output logic          scl_hold_o,
  output logic          pend_n_o,
  output ctrl_t         ctrl_o
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] sreg_q, rbuf_q;
  logic          hold_q, pend_n_q, start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      sreg_q   <= '0;
      rbuf_q   <= '0;
      hold_q   <= 1'b0;
      pend_n_q <= 1'b1;
      start_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (done_i) begin
        pend_n_q <= 1'b0;
        if (!ctrl_q.tx_mode) begin
          rbuf_q <= rx_byte_i;
          sreg_q <= rx_byte_i;
          hold_q <= 1'b1;
        end
      end else if (st_i && !st_a0_i) begin
        pend_n_q <= 1'b1;
      end
      if (st_i && st_wr_i) begin
        if (st_a0_i) begin
          ctrl_q <= ctrl_t'(st_data_i[1:0]);
        end else begin
          sreg_q  <= st_data_i;
          start_q <= ctrl_q.ser_en && ctrl_q.tx_mode;
        end
      end
      // read completion frees the bus and asks for the next byte
      if (end_dread_i) begin
        hold_q  <= 1'b0;
        start_q <= ctrl_q.ser_en && !ctrl_q.tx_mode;
      end
    end
  end

  assign start_o    = start_q;
  assign tx_dir_o   = ctrl_q.tx_mode;
  assign tx_byte_o  = sreg_q;
  assign rbuf_o     = rbuf_q;
  assign scl_hold_o = hold_q;
  assign pend_n_o   = pend_n_q;
  assign ctrl_o     = ctrl_q;

  p_hold_after_rx_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_q.tx_mode) |=> scl_hold_o);
  p_release_after_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_dread_i && !done_i) |=> !scl_hold_o);
  p_start_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(ctrl_q.ser_en));
  p_pending_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !pend_n_o);
endmodule

// File: rtl/i2c_byte_buf.sv
module i2c_byte_buf
  import i2c_bb_pkg::*;
#(
  parameter bit SLOW_CLK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              a0_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              start_o,
  output logic              tx_dir_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              scl_hold_o,
  output logic              pend_n_o,
  output logic              viol_o
);
  logic              st, st_wr, st_a0, end_dread;
  logic [BYTE_W-1:0] st_data, rbuf;
  logic [BYTE_W-1:0] status;
  ctrl_t             ctrl;

  i2c_bb_host_port #(.SLOW_CLK(SLOW_CLK), .DW(BYTE_W)) u_port (
    .clk_i, .rst_ni, .cs_ni, .rd_ni, .wr_ni, .a0_i, .data_i,
    .st_o(st), .st_wr_o(st_wr), .st_a0_o(st_a0), .st_data_o(st_data),
    .end_dread_o(end_dread), .viol_o
  );

  i2c_bb_byte_core #(.DW(BYTE_W)) u_core (
    .clk_i, .rst_ni,
    .st_i(st), .st_wr_i(st_wr), .st_a0_i(st_a0), .st_data_i(st_data),
    .end_dread_i(end_dread), .done_i, .rx_byte_i,
    .start_o, .tx_dir_o, .tx_byte_o, .rbuf_o(rbuf),
    .scl_hold_o, .pend_n_o, .ctrl_o(ctrl)
  );

  always_comb begin
    status              = '0;
    status[ST_PEND_BIT] = pend_n_o;
    status[ST_VIOL_BIT] = viol_o;
    status[1]           = ctrl.ser_en;
    status[0]           = ctrl.tx_mode;
  end

  assign data_o = a0_i ? status : rbuf;

  p_rx_start_releases_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !tx_dir_o) |-> !scl_hold_o);
endmodule

// File: tb/i2c_byte_buf_bench.sv
module i2c_byte_buf_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = '0, rx_byte = '0;
  logic       done = 1'b0;
  logic [7:0] dout, tx_byte, dout_b, tx_byte_b;
  logic       start, tx_dir, hold, pend_n, viol;
  logic       start_b, tx_dir_b, hold_b, pend_n_b, viol_b;

  int n_chk = 0, n_fail = 0, n_done = 0;
  logic [8:0] exp_q[$];
  logic [7:0] rbuf_exp = 8'h00;
  logic       tx_mode_m = 1'b0;
  logic       finished = 1'b0;

  always #4 clk = ~clk;

  i2c_byte_buf u_i2c_byte_buf (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .a0_i(a0), .data_i(din), .data_o(dout), .start_o(start), .tx_dir_o(tx_dir),
    .tx_byte_o(tx_byte), .done_i(done), .rx_byte_i(rx_byte),
    .scl_hold_o(hold), .pend_n_o(pend_n), .viol_o(viol)
  );

  i2c_byte_buf #(.SLOW_CLK(1'b1)) u_slow (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .a0_i(a0), .data_i(din), .data_o(dout_b), .start_o(start_b), .tx_dir_o(tx_dir_b),
    .tx_byte_o(tx_byte_b), .done_i(done), .rx_byte_i(rx_byte),
    .scl_hold_o(hold_b), .pend_n_o(pend_n_b), .viol_o(viol_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle strobe access followed by an idle gap
  task automatic bus(input bit wr, input bit sel, input logic [7:0] d,
                     output logic [7:0] q, output logic h_in, output logic h_after);
    @(negedge clk);
    cs_n = 1'b0; a0 = sel; din = d;
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    @(negedge clk);
    q = dout; h_in = hold;
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    h_after = hold;
    if (wr && sel) tx_mode_m = d[0];
    repeat (7) @(negedge clk);
  endtask

  // scoreboard monitor: every start pulse must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && start) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected start", {tx_dir, tx_byte}, 0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(tx_dir == e[8], "R3/R6 start direction", tx_dir, e[8]);
        if (e[8]) chk(tx_byte == e[7:0], "R3 transmitted byte", tx_byte, e[7:0]);
      end
    end
  end

  // bit-engine model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && start) begin
        repeat (3) @(negedge clk);
        rx_byte = 8'hA0 + 8'(n_done);
        if (!tx_mode_m) rbuf_exp = rx_byte;
        n_done++;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic h1, h2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    a0 = 1'b1;
    #1;
    chk(hold == 1'b0,   "R1 hold", hold, 0);
    chk(pend_n == 1'b1, "R1 pending", pend_n, 1);
    chk(start == 1'b0,  "R1 start", start, 0);
    chk(viol == 1'b0,   "R1 viol", viol, 0);
    chk(dout == 8'h80,  "R1 status", dout, 8'h80);

    // transmit mode, serial disabled
    bus(1, 1, 8'h01, q, h1, h2);
    bus(0, 1, 8'h00, q, h1, h2);
    chk(q == 8'h81, "R2 status after control write", q, 8'h81);
    bus(1, 0, 8'h3C, q, h1, h2);
    chk(tx_byte == 8'h3C, "R4 latched while disabled", tx_byte, 8'h3C);
    bus(0, 0, 8'h00, q, h1, h2);
    chk(q == 8'h00, "R2 data select returns buffer", q, 8'h00);

    // spacing: starts 3 cycles apart, then 2 apart
    @(negedge clk); cs_n = 0; rd_n = 0; a0 = 1;
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk);
    @(negedge clk); cs_n = 0; wr_n = 0; a0 = 0; din = 8'h77;
    @(negedge clk); cs_n = 1; wr_n = 1;
    @(negedge clk);
    chk(viol == 1'b1,     "R8 early access flagged", viol, 1);
    chk(tx_byte == 8'h3C, "R8 early write ignored", tx_byte, 8'h3C);
    chk(viol_b == 1'b0,   "R10 slow spacing of 3 accepted", viol_b, 0);
    chk(tx_byte_b == 8'h77, "R10 slow instance took write", tx_byte_b, 8'h77);
    repeat (8) @(negedge clk);
    cs_n = 0; rd_n = 0; a0 = 1;
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk); cs_n = 0; rd_n = 0;
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk);
    chk(viol_b == 1'b1, "R10 slow spacing of 2 rejected", viol_b, 1);
    chk(viol == 1'b1,   "R8 violation sticky", viol, 1);
    repeat (8) @(negedge clk);

    // enable transmit and send the address byte
    bus(1, 1, 8'h03, q, h1, h2);
    chk(exp_q.size() == 0, "R4 enable alone does not start", exp_q.size(), 0);
    exp_q.push_back({1'b1, 8'hC3});
    bus(1, 0, 8'hC3, q, h1, h2);
    chk(pend_n == 1'b0, "R9 pending after byte", pend_n, 0);
    bus(0, 1, 8'h00, q, h1, h2);
    chk(q == 8'h07, "R2 status pending and violation", q, 8'h07);
    chk(hold == 1'b0, "R5 no hold in transmit", hold, 0);

    // switch to receive
    bus(1, 1, 8'h02, q, h1, h2);
    chk(pend_n == 1'b0, "R9 control access keeps pending", pend_n, 0);
    exp_q.push_back({1'b0, 8'h00});
    bus(0, 0, 8'h00, q, h1, h2);
    chk(q == 8'h00, "R7 dummy read stale", q, 8'h00);
    chk(hold == 1'b1, "R5 hold after received byte", hold, 1);
    chk(pend_n == 1'b0, "R9 pending after received byte", pend_n, 0);
    chk(dout == rbuf_exp, "R5 buffer holds received byte", dout, rbuf_exp);

    exp_q.push_back({1'b0, 8'h00});
    begin
      logic [7:0] first;
      first = rbuf_exp;
      bus(0, 0, 8'h00, q, h1, h2);
      chk(q == first, "R7 first real byte", q, first);
      chk(h1 == 1'b1, "R6 hold during read strobe", h1, 1);
      chk(h2 == 1'b0, "R6 released after strobe", h2, 0);
      chk(hold == 1'b1, "R5 hold after next byte", hold, 1);
    end

    // disable serial, final read releases without new start
    bus(1, 1, 8'h00, q, h1, h2);
    chk(hold == 1'b1, "R6 control write keeps hold", hold, 1);
    begin
      logic [7:0] second;
      second = rbuf_exp;
      bus(0, 0, 8'h00, q, h1, h2);
      chk(q == second, "R7 second byte", q, second);
      chk(h2 == 1'b0, "R6 released while disabled", h2, 0);
      chk(hold == 1'b0, "R6 no restart while disabled", hold, 0);
      chk(pend_n == 1'b1, "R9 data read clears pending", pend_n, 1);
    end
    chk(exp_q.size() == 0, "R3 all expected starts seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule